// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Claim and Complete

This block is the decision core of a platform-level interrupt controller. It watches a vector of level interrupt lines, turns their edges into a pending vector, and keeps a claimed vector of sources that a handler currently owns. For every target context it takes an enable mask and a priority threshold, and from these it drives one external-interrupt line per context. The register file that holds source priorities, enables and thresholds lives outside the block and feeds it over plain input ports.

Software on a context claims by pulsing `claim_req` with a context index. The next cycle, the block returns the identifier of the best eligible source on `grant_id` and pulses `grant_valid`. In that same cycle the winner's pending bit is cleared and its claimed bit is set. When the handler finishes, it pulses `done_req` with the source identifier, and the claimed bit drops. Source 0 is reserved and means "nothing to serve".

A line that stays high after its claim does not raise the interrupt again. It has to fall and rise once more before it becomes pending again.

Top module: `irq_arbiter`

## Requirements
- R1: A rising edge on `src_level[i]` sets the pending bit of source i, and a falling edge clears it. Source 0 never becomes pending and is never granted.
- R2: For context c, source i is a candidate only when it is pending, not claimed, and bit `c*NUM_SRC+i` of `ctx_enable` is 1. Contexts are independent.
- R3: A candidate counts only when its priority `src_prio[i*PRIO_W +: PRIO_W]` is strictly greater than the threshold `ctx_thresh[c*PRIO_W +: PRIO_W]`. Equal priority never interrupts.
- R4: `ext_irq[c]` is a register. It equals, one clock later, whether any candidate of context c passes R3, so it both rises and falls one edge after the state changes.
- R5: A claim returns the passing candidate with the highest priority. On equal priority the lowest source identifier wins.
- R6: A claim with no passing candidate, or with a context index of NUM_CTX or more, returns identifier 0 and changes no pending or claimed bit.
- R7: A successful claim clears the winner's pending bit and sets its claimed bit in one edge. The source cannot interrupt again until it is completed and its line rises anew.
- R8: A complete with `done_id` below NUM_SRC clears that source's claimed bit. A complete with a larger identifier is ignored.
- R9: `grant_valid` is high for exactly the cycle after each cycle in which `claim_req` is high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC | Interrupt lines, bit i is source i |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source, field i at i*PRIO_W |
| ctx_enable | input | NUM_CTX*NUM_SRC | Enable mask per context, context c at c*NUM_SRC |
| ctx_thresh | input | NUM_CTX*PRIO_W | Threshold per context, context c at c*PRIO_W |
| claim_req | input | 1 | Claim strobe |
| claim_ctx | input | CTX_W | Context that claims |
| done_req | input | 1 | Complete strobe |
| done_id | input | ID_W | Source identifier being completed |
| ext_irq | output | NUM_CTX | External interrupt line per context |
| grant_valid | output | 1 | Pulses one cycle after a claim |
| grant_id | output | ID_W | Identifier returned by the claim, 0 when none |

## Verification
The bench targets the threshold edge where priority equals threshold. A design that compares with greater-or-equal would interrupt there and grant the source. It also checks ties between equal priorities, where a tree that favours the right operand would return the higher identifier. Other cases are a line that re-rises while still claimed, which a design that ignores the claimed mask would re-signal, and an out-of-range complete, which a design that truncates the identifier would apply to a real source. Finally, it checks that one context's enables cannot raise the other context's line, and that a falling line withdraws a pending request.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DEF_NUM_SRC = 16;
    localparam int DEF_NUM_CTX = 2;
    localparam int DEF_PRIO_W  = 3;

    function automatic int idw(input int nsrc);
        return $clog2(nsrc + 1);
    endfunction

    function automatic int ctxw(input int nctx);
        return (nctx > 1) ? $clog2(nctx) : 1;
    endfunction
endpackage

// File: rtl/irq_max_tree.sv
module irq_max_tree #(
    parameter int NUM_SRC = irq_pkg::DEF_NUM_SRC,
    parameter int PRIO_W  = irq_pkg::DEF_PRIO_W,
    parameter int ID_W    = irq_pkg::idw(NUM_SRC)
) (
    input  logic [NUM_SRC*PRIO_W-1:0] prio_vec,
    output logic [PRIO_W-1:0]         best_prio,
    output logic [ID_W-1:0]           best_id
);
    localparam int LEAVES = 1 << $clog2(NUM_SRC);
    localparam int NODES  = 2 * LEAVES - 1;

    logic [PRIO_W-1:0] node_prio [NODES];
    logic [ID_W-1:0]   node_id   [NODES];

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NUM_SRC) begin : g_real
            assign node_prio[LEAVES-1+i] = prio_vec[i*PRIO_W +: PRIO_W];
            assign node_id[LEAVES-1+i]   = ID_W'(i);
        end else begin : g_pad
            assign node_prio[LEAVES-1+i] = '0;
            assign node_id[LEAVES-1+i]   = '0;
        end
    end

    // left child always holds lower identifiers; right wins only when strictly higher
    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        logic take_right;
        assign take_right   = node_prio[2*k+2] > node_prio[2*k+1];
        assign node_prio[k] = take_right ? node_prio[2*k+2] : node_prio[2*k+1];
        assign node_id[k]   = take_right ? node_id[2*k+2]   : node_id[2*k+1];
    end

    assign best_prio = node_prio[0];
    assign best_id   = node_id[0];
endmodule

// File: rtl/irq_ctx_select.sv
module irq_ctx_select #(
    parameter int NUM_SRC = irq_pkg::DEF_NUM_SRC,
    parameter int PRIO_W  = irq_pkg::DEF_PRIO_W,
    parameter int ID_W    = irq_pkg::idw(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        clmd,
    input  logic [NUM_SRC-1:0]        enable,
    input  logic [NUM_SRC*PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thresh,
    output logic                      win_any,
    output logic [ID_W-1:0]           win_id
);
    logic [NUM_SRC*PRIO_W-1:0] masked;
    logic [PRIO_W-1:0]         top_prio;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mask
        logic elig;
        assign elig = pend[i] & ~clmd[i] & enable[i]
                    & (prio[i*PRIO_W +: PRIO_W] > thresh);
        assign masked[i*PRIO_W +: PRIO_W] = elig ? prio[i*PRIO_W +: PRIO_W] : '0;
    end

    irq_max_tree #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_tree (
        .prio_vec  (masked),
        .best_prio (top_prio),
        .best_id   (win_id)
    );

    // any eligible source has priority above a threshold >= 0, hence nonzero
    assign win_any = top_prio != '0;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int NUM_SRC = irq_pkg::DEF_NUM_SRC,
    parameter int NUM_CTX = irq_pkg::DEF_NUM_CTX,
    parameter int PRIO_W  = irq_pkg::DEF_PRIO_W,
    parameter int ID_W    = irq_pkg::idw(NUM_SRC),
    parameter int CTX_W   = irq_pkg::ctxw(NUM_CTX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_level,
    input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
    input  logic [NUM_CTX*NUM_SRC-1:0] ctx_enable,
    input  logic [NUM_CTX*PRIO_W-1:0] ctx_thresh,
    input  logic                      claim_req,
    input  logic [CTX_W-1:0]          claim_ctx,
    input  logic                      done_req,
    input  logic [ID_W-1:0]           done_id,
    output logic [NUM_CTX-1:0]        ext_irq,
    output logic                      grant_valid,
    output logic [ID_W-1:0]           grant_id
);
    typedef struct packed {
        logic [NUM_SRC-1:0] lvl;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] clmd;
        logic [NUM_CTX-1:0] irq;
        logic               gvalid;
        logic [ID_W-1:0]    gid;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CTX-1:0] win_any;
    logic [ID_W-1:0]    win_id [NUM_CTX];

    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        irq_ctx_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
            .pend    (st_q.pend),
            .clmd    (st_q.clmd),
            .enable  (ctx_enable[c*NUM_SRC +: NUM_SRC]),
            .prio    (src_prio),
            .thresh  (ctx_thresh[c*PRIO_W +: PRIO_W]),
            .win_any (win_any[c]),
            .win_id  (win_id[c])
        );
    end

    logic [NUM_SRC-1:0] rise, fall;
    logic               sel_ok;
    logic [ID_W-1:0]    sel_id;

    always_comb begin
        st_d = st_q;

        rise = src_level & ~st_q.lvl;
        fall = ~src_level & st_q.lvl;

        st_d.lvl    = src_level;
        st_d.lvl[0] = 1'b0;
        st_d.pend   = (st_q.pend | rise) & ~fall;
        st_d.pend[0] = 1'b0;

        st_d.irq = win_any;

        sel_ok = 1'b0;
        sel_id = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (int'(claim_ctx) == c) begin
                sel_ok = win_any[c];
                sel_id = win_id[c];
            end
        end

        if (done_req && (int'(done_id) < NUM_SRC)) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (ID_W'(i) == done_id) st_d.clmd[i] = 1'b0;
            end
        end

        st_d.gvalid = claim_req;
        st_d.gid    = '0;
        if (claim_req && sel_ok) begin
            st_d.gid = sel_id;
            // claim overrides any same-cycle line change on the winner
            for (int i = 0; i < NUM_SRC; i++) begin
                if (ID_W'(i) == sel_id) begin
                    st_d.pend[i] = 1'b0;
                    st_d.clmd[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_irq     = st_q.irq;
    assign grant_valid = st_q.gvalid;
    assign grant_id    = st_q.gid;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
    parameter int NUM_SRC = 16,
    parameter int NUM_CTX = 2,
    parameter int ID_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               claim_req,
    input logic               done_req,
    input logic [ID_W-1:0]    done_id,
    input logic [NUM_CTX-1:0] ext_irq,
    input logic               grant_valid,
    input logic [ID_W-1:0]    grant_id,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] clmd_q
);
    logic [NUM_SRC-1:0] clmd_sh, pend_sh;
    assign clmd_sh = clmd_q >> grant_id;
    assign pend_sh = pend_q >> grant_id;

    AST_SRC0_NEVER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);                                                      // R1

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_irq != '0) |-> ($past(pend_q & ~clmd_q) != '0));             // R4

    AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (int'(grant_id) < NUM_SRC));                      // R5

    AST_CLAIM_MOVES_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && grant_id != '0) |-> (clmd_sh[0] && !pend_sh[0])); // R7

    AST_BAD_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_req && int'(done_id) >= NUM_SRC && !claim_req) |=> $stable(clmd_q)); // R8

    AST_GRANT_FOLLOWS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        claim_req |=> grant_valid);                                       // R9

    AST_NO_GRANT_WITHOUT_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        !claim_req |=> !grant_valid);                                     // R9
endmodule

bind irq_arbiter irq_arbiter_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .ID_W    (ID_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .claim_req   (claim_req),
    .done_req    (done_req),
    .done_id     (done_id),
    .ext_irq     (ext_irq),
    .grant_valid (grant_valid),
    .grant_id    (grant_id),
    .pend_q      (st_q.pend),
    .clmd_q      (st_q.clmd)
);

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NC = 2;
    localparam int PW = 3;
    localparam int IW = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NS-1:0]   src_level = '0;
    logic [NS*PW-1:0] src_prio = '0;
    logic [NC*NS-1:0] ctx_enable = '0;
    logic [NC*PW-1:0] ctx_thresh = '0;
    logic            claim_req = 1'b0;
    logic [0:0]      claim_ctx = '0;
    logic            done_req = 1'b0;
    logic [IW-1:0]   done_id = '0;
    logic [NC-1:0]   ext_irq;
    logic            grant_valid;
    logic [IW-1:0]   grant_id;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .src_prio(src_prio),
        .ctx_enable(ctx_enable), .ctx_thresh(ctx_thresh),
        .claim_req(claim_req), .claim_ctx(claim_ctx),
        .done_req(done_req), .done_id(done_id),
        .ext_irq(ext_irq), .grant_valid(grant_valid), .grant_id(grant_id)
    );

    typedef struct packed {
        logic [15:0] lvl;
        logic [63:0] pnib;   // nibble i holds the priority of source i
        logic [15:0] en;
        logic [2:0]  th;
        logic [4:0]  exp_id;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{16'h0006, 64'h0000_0000_0000_0530, 16'hFFFF, 3'd0, 5'd2},  // R5 higher wins
        '{16'h0030, 64'h0000_0000_0066_0000, 16'hFFFF, 3'd2, 5'd4},  // R5 tie -> lower id
        '{16'h0100, 64'h0000_0004_0000_0000, 16'hFFFF, 3'd4, 5'd0},  // R3 equal threshold
        '{16'h8002, 64'h7000_0000_0000_0010, 16'h0002, 3'd0, 5'd1},  // R2 disabled source
        '{16'h0001, 64'h0000_0000_0000_0007, 16'hFFFF, 3'd0, 5'd0},  // R1 source 0 reserved
        '{16'hFFFE, 64'h2222_2232_2222_2220, 16'hFFFF, 3'd1, 5'd9},  // R5 wide scan
        '{16'h0080, 64'h0000_0000_7000_0000, 16'hFFFF, 3'd7, 5'd0}   // R3 max threshold
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_level = '0; src_prio = '0; ctx_enable = '0; ctx_thresh = '0;
        claim_req = 1'b0; done_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_claim(input int ctx, output int id, output int vld);
        claim_ctx = 1'(ctx);
        claim_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        claim_req = 1'b0;
        id  = int'(grant_id);
        vld = int'(grant_valid);
    endtask

    task automatic do_done(input int id);
        done_id  = IW'(id);
        done_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        done_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int id, vld;

        do_reset();
        check("R4 reset irq", int'(ext_irq), 0);
        check("R9 reset grant_valid", int'(grant_valid), 0);

        foreach (VECS[v]) begin
            do_reset();
            for (int i = 0; i < NS; i++) src_prio[i*PW +: PW] = VECS[v].pnib[i*4 +: PW];
            ctx_enable[0 +: NS] = VECS[v].en;
            ctx_thresh[0 +: PW] = VECS[v].th;
            src_level = VECS[v].lvl;
            settle();
            check($sformatf("R4 vec%0d irq", v), int'(ext_irq[0]), int'(VECS[v].exp_id != 0));
            do_claim(0, id, vld);
            check($sformatf("R5 vec%0d grant", v), id, int'(VECS[v].exp_id));
            check($sformatf("R9 vec%0d valid", v), vld, 1);
        end

        // claim / complete sequence
        do_reset();
        src_prio[3*PW +: PW] = 3'd5;
        src_prio[6*PW +: PW] = 3'd5;
        ctx_enable[0 +: NS] = 16'hFFFF;
        src_level = 16'h0048;
        settle();
        check("R4 two pending", int'(ext_irq[0]), 1);
        do_claim(0, id, vld);
        check("R5 tie first claim", id, 3);
        @(negedge clk);
        check("R9 valid drops", int'(grant_valid), 0);
        @(negedge clk);
        check("R7 other still raises", int'(ext_irq[0]), 1);
        do_claim(0, id, vld);
        check("R7 second claim", id, 6);
        settle();
        check("R7 all claimed quiet", int'(ext_irq[0]), 0);
        do_claim(0, id, vld);
        check("R6 empty claim id", id, 0);
        check("R6 empty claim valid", vld, 1);
        src_level[6] = 1'b0;
        settle();
        src_level[6] = 1'b1;
        settle();
        check("R2 re-raised while claimed", int'(ext_irq[0]), 0);
        do_done(22);
        settle();
        check("R8 out of range complete ignored", int'(ext_irq[0]), 0);
        do_done(6);
        settle();
        check("R8 complete releases", int'(ext_irq[0]), 1);
        do_claim(0, id, vld);
        check("R7 reclaim after complete", id, 6);
        do_claim(0, id, vld);
        check("R7 completed without new edge", id, 0);
        src_prio[2*PW +: PW] = 3'd4;
        src_level[2] = 1'b1;
        settle();
        check("R1 rise sets pending", int'(ext_irq[0]), 1);
        src_level[2] = 1'b0;
        settle();
        check("R1 fall clears pending", int'(ext_irq[0]), 0);

        // context independence
        do_reset();
        src_prio[6*PW +: PW] = 3'd5;
        ctx_enable[1*NS +: NS] = 16'h0040;
        src_level = 16'h0040;
        settle();
        check("R2 only ctx1 raised", int'(ext_irq), 2);
        do_claim(0, id, vld);
        check("R2 ctx0 claim empty", id, 0);
        do_claim(1, id, vld);
        check("R2 ctx1 claim", id, 6);

        // threshold changes take one edge
        do_reset();
        src_prio[5*PW +: PW] = 3'd3;
        ctx_enable[0 +: NS] = 16'hFFFF;
        src_level = 16'h0020;
        settle();
        check("R4 raised", int'(ext_irq[0]), 1);
        ctx_thresh[0 +: PW] = 3'd3;
        @(posedge clk);
        @(negedge clk);
        check("R3 equal threshold masks", int'(ext_irq[0]), 0);
        ctx_thresh[0 +: PW] = 3'd2;
        @(posedge clk);
        @(negedge clk);
        check("R4 one edge to rise", int'(ext_irq[0]), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule